// File: doc/BRIEF.md
# DMA Channel Register Front End

This block is the software-visible register set of a single memory-to-memory DMA channel. It sits behind a 64-bit memory-mapped slave port that accepts 32-bit and 64-bit accesses. It holds a control word and a staged descriptor made of a config word, a byte count, a destination address and a source address. It also holds a read-only set of executing copies that the transfer engine works from. Software must claim the channel before a run request takes effect. Claiming the channel wipes the staged descriptor back to its defaults. While run is high, claim cannot be dropped.

When software sets run on a claimed channel, the block copies the staged descriptor into the executing registers. It then raises a one-cycle start pulse towards a transfer engine, which lies outside this block. The engine reports completion and errors back. It may also post progress updates to the executing byte count and addresses. Two level interrupt lines, one for done and one for error, are formed from the status bits and their enables.

Top module: `dma_chan_regs`

## Requirements
- R1: After the asynchronous active-low reset, the following hold. The control word, the staged count, destination and source, and all executing registers read zero. The staged config reads 0x6600_0000, which is 6 in its write-size field (bits 27:24) and 6 in its read-size field (bits 31:28). Both interrupt lines and the start pulse are low.
- R2: Only the low 12 bits of the access address select a register. Upper address bits have no effect.
- R3: A control write that sets claim (bit 0) while claim is currently clear resets the staged count, destination and source to zero and the staged config to 0x6600_0000. A control write made while claim is already set leaves the staged registers alone.
- R4: A control write that clears claim while run (bit 1) is set stores claim as 1.
- R5: A control write to an unclaimed channel, or one that leaves claim clear while run was low, stores the written word with run forced to 0. It raises no start pulse and leaves both interrupt lines unchanged.
- R6: A control write with run set to a claimed channel starts a transfer. In the cycle after the write, the start pulse is high for exactly one cycle. The executing config, count, destination and source then equal the staged values. Done (bit 30) and error (bit 31) status are cleared.
- R7: The staged and executing 64-bit registers sit at offsets 0x008, 0x010 and 0x018 (count, destination, source), and executing ones at 0x108, 0x110 and 0x118. Each is accessed whole by an 8-byte access at its base, or as low and high halves by 4-byte accesses at base and base+4. A 4-byte access uses data bits 31:0, and a half write changes only its own half. Control is at 0x000, staged config at 0x004 and executing config at 0x104, all 4-byte only.
- R8: Writes to the executing registers (0x104 to 0x11F) have no effect.
- R9: On every control write that passes the claim gate of R5, and on every engine event, the done line is set to done status AND done enable (bit 14). At the same moments the error line is set to error status AND error enable (bit 15).
- R10: An engine done pulse clears run and sets done status. An engine error pulse sets error status. Each takes effect on top of any control write in the same cycle.
- R11: An engine progress update loads the executing count, destination and source. A transfer start in the same cycle takes priority over it.
- R12: An access with a size other than 4 or 8 bytes, an undefined offset, or an offset that does not allow that size, reads zero and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; low 12 bits decoded |
| acc_size | input | 4 | Access size in bytes (4 or 8 valid) |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, combinational, zero when not reading |
| eng_start | output | 1 | One-cycle transfer start pulse |
| eng_cfg | output | 32 | Executing config |
| eng_bytes | output | 64 | Executing byte count |
| eng_dst | output | 64 | Executing destination |
| eng_src | output | 64 | Executing source |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_upd | input | 1 | Engine progress update strobe |
| eng_upd_bytes | input | 64 | Updated executing count |
| eng_upd_dst | input | 64 | Updated executing destination |
| eng_upd_src | input | 64 | Updated executing source |
| irq_done | output | 1 | Done interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The bench targets the claim handshake edges. The first is a run request on an unclaimed channel; a design that ignored the gate would start a transfer with a stale descriptor. The second is re-claiming an already claimed channel; a design that reset on level rather than on the rising claim would wipe a descriptor software had just written. The third is clearing claim while running; a design that did not force claim would release a channel whose engine is still live. The bench also writes status and enable bits to an unclaimed channel. If interrupts were combinational from the control word, they would fire there. Further checks cover half-word writes, which would corrupt the other half if decoded as whole writes, and a start coinciding with a progress update, where wrong priority would leave the executing copy mismatched with the staged one.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int OFF_W = 12;
  localparam int NDESC = 3;
  localparam int IDX_BYTES = 0;
  localparam int IDX_DST   = 1;
  localparam int IDX_SRC   = 2;

  localparam int B_CLAIM   = 0;
  localparam int B_RUN     = 1;
  localparam int B_DONE_IE = 14;
  localparam int B_ERR_IE  = 15;
  localparam int B_DONE    = 30;
  localparam int B_ERR     = 31;

  localparam logic [OFF_W-1:0] OFF_CTRL = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CFG  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_XCFG = 12'h104;
  localparam logic [3:0]       SIZE_DEFAULT = 4'd6;

  typedef struct packed {
    logic             ctrl;
    logic             cfg;
    logic [NDESC-1:0] lo;
    logic [NDESC-1:0] hi;
    logic             exec_hit;
  } wsel_t;

  // base offset of staged 64-bit word i
  function automatic logic [OFF_W-1:0] next_off(input int i);
    return OFF_W'(32'h008 + 32'(8 * i));
  endfunction

  // base offset of executing 64-bit word i
  function automatic logic [OFF_W-1:0] exec_off(input int i);
    return OFF_W'(32'h108 + 32'(8 * i));
  endfunction

  function automatic logic [OFF_W-1:0] hi_off(input logic [OFF_W-1:0] base);
    return base | OFF_W'(4);
  endfunction

  function automatic logic [31:0] cfg_reset();
    return {SIZE_DEFAULT, SIZE_DEFAULT, 24'h0};
  endfunction

  function automatic logic [63:0] put_half(input logic [63:0] old,
                                           input logic [31:0] d,
                                           input logic        hi);
    return hi ? {d, old[31:0]} : {old[63:32], d};
  endfunction

  // {err, done} interrupt levels from a control word
  function automatic logic [1:0] irq_level(input logic [31:0] c);
    return {c[B_ERR] & c[B_ERR_IE], c[B_DONE] & c[B_DONE_IE]};
  endfunction

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dma_chan_pkg::*;
(
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [OFF_W-1:0] off,
  input  logic [3:0]       acc_size,
  output wsel_t            wsel
);

  logic is4, is8, wr;

  assign is4 = (acc_size == 4'd4);
  assign is8 = (acc_size == 4'd8);
  assign wr  = acc_valid && acc_write;

  always_comb begin
    wsel = '0;
    if (wr && is4) begin
      wsel.ctrl = (off == OFF_CTRL);
      wsel.cfg  = (off == OFF_CFG);
      for (int i = 0; i < NDESC; i++) begin
        wsel.lo[i] = (off == next_off(i));
        wsel.hi[i] = (off == hi_off(next_off(i)));
      end
    end else if (wr && is8) begin
      for (int i = 0; i < NDESC; i++) begin
        wsel.lo[i] = (off == next_off(i));
        wsel.hi[i] = (off == next_off(i));
      end
    end
    if (wr && (is4 || is8)) begin
      if (off == OFF_XCFG) wsel.exec_hit = 1'b1;
      for (int i = 0; i < NDESC; i++) begin
        if (off == exec_off(i) || off == hi_off(exec_off(i))) wsel.exec_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dma_chan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic [31:0] wval,
  input  logic        eng_done,
  input  logic        eng_err,
  output logic [31:0] ctrl_q,
  output logic        claim_rise,
  output logic        start_now,
  output logic        start_q,
  output logic        gate_open,
  output logic        irq_eval,
  output logic        irq_done_q,
  output logic        irq_err_q
);

  logic [31:0] v;
  logic [31:0] ctrl_n;

  // claim is pinned while the channel runs
  always_comb begin
    v = wval;
    if (ctrl_q[B_RUN] && !wval[B_CLAIM]) v[B_CLAIM] = 1'b1;
  end

  assign claim_rise = wr_ctrl && !ctrl_q[B_CLAIM] && wval[B_CLAIM];
  assign gate_open  = wr_ctrl && ctrl_q[B_CLAIM] && (ctrl_q[B_RUN] || v[B_CLAIM]);
  assign start_now  = gate_open && v[B_RUN];
  assign irq_eval   = gate_open || eng_done || eng_err;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl) begin
      ctrl_n = v;
      if (!gate_open) ctrl_n[B_RUN] = 1'b0;
      if (start_now) begin
        ctrl_n[B_DONE] = 1'b0;
        ctrl_n[B_ERR]  = 1'b0;
      end
    end
    if (eng_done) begin
      ctrl_n[B_RUN]  = 1'b0;
      ctrl_n[B_DONE] = 1'b1;
    end
    if (eng_err) ctrl_n[B_ERR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      start_q    <= 1'b0;
      irq_done_q <= 1'b0;
      irq_err_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      start_q <= start_now;
      if (irq_eval) {irq_err_q, irq_done_q} <= irq_level(ctrl_n);
    end
  end

endmodule

// File: rtl/dcr_desc.sv
module dcr_desc
  import dma_chan_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  wsel_t                  wsel,
  input  logic [63:0]            wdata,
  input  logic                   claim_rise,
  input  logic                   start_now,
  input  logic                   eng_upd,
  input  logic [NDESC-1:0][63:0] upd_val,
  output logic [31:0]            cfg_q,
  output logic [31:0]            xcfg_q,
  output logic [NDESC-1:0][63:0] next_q,
  output logic [NDESC-1:0][63:0] exec_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= cfg_reset();
    else if (claim_rise) cfg_q <= cfg_reset();
    else if (wsel.cfg)   cfg_q <= wdata[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         xcfg_q <= '0;
    else if (start_now) xcfg_q <= cfg_q;
  end

  for (genvar g = 0; g < NDESC; g++) begin : g_word
    logic [63:0] nxt_r, exe_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       nxt_r <= '0;
      else if (claim_rise)              nxt_r <= '0;
      else if (wsel.lo[g] && wsel.hi[g]) nxt_r <= wdata;
      else if (wsel.lo[g])              nxt_r <= put_half(nxt_r, wdata[31:0], 1'b0);
      else if (wsel.hi[g])              nxt_r <= put_half(nxt_r, wdata[31:0], 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         exe_r <= '0;
      else if (start_now) exe_r <= nxt_r;
      else if (eng_upd)   exe_r <= upd_val[g];
    end

    assign next_q[g] = nxt_r;
    assign exec_q[g] = exe_r;
  end

endmodule

// File: rtl/dcr_rdmux.sv
module dcr_rdmux
  import dma_chan_pkg::*;
(
  input  logic                   acc_valid,
  input  logic                   acc_write,
  input  logic [OFF_W-1:0]       off,
  input  logic [3:0]             acc_size,
  input  logic [31:0]            ctrl_q,
  input  logic [31:0]            cfg_q,
  input  logic [31:0]            xcfg_q,
  input  logic [NDESC-1:0][63:0] next_q,
  input  logic [NDESC-1:0][63:0] exec_q,
  output logic [63:0]            acc_rdata
);

  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write) begin
      if (acc_size == 4'd4) begin
        if (off == OFF_CTRL) acc_rdata = {32'h0, ctrl_q};
        if (off == OFF_CFG)  acc_rdata = {32'h0, cfg_q};
        if (off == OFF_XCFG) acc_rdata = {32'h0, xcfg_q};
        for (int i = 0; i < NDESC; i++) begin
          if (off == next_off(i))         acc_rdata = {32'h0, next_q[i][31:0]};
          if (off == hi_off(next_off(i))) acc_rdata = {32'h0, next_q[i][63:32]};
          if (off == exec_off(i))         acc_rdata = {32'h0, exec_q[i][31:0]};
          if (off == hi_off(exec_off(i))) acc_rdata = {32'h0, exec_q[i][63:32]};
        end
      end else if (acc_size == 4'd8) begin
        for (int i = 0; i < NDESC; i++) begin
          if (off == next_off(i)) acc_rdata = next_q[i];
          if (off == exec_off(i)) acc_rdata = exec_q[i];
        end
      end
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_size,
  input  logic [63:0]       acc_wdata,
  output logic [63:0]       acc_rdata,
  output logic              eng_start,
  output logic [31:0]       eng_cfg,
  output logic [63:0]       eng_bytes,
  output logic [63:0]       eng_dst,
  output logic [63:0]       eng_src,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_upd,
  input  logic [63:0]       eng_upd_bytes,
  input  logic [63:0]       eng_upd_dst,
  input  logic [63:0]       eng_upd_src,
  output logic              irq_done,
  output logic              irq_err
);

  logic [OFF_W-1:0]       off;
  logic                   unused_addr_hi;
  wsel_t                  wsel;
  logic [31:0]            ctrl_q, cfg_q, xcfg_q;
  logic [NDESC-1:0][63:0] next_q, exec_q, upd_val;
  logic                   claim_rise, start_now, gate_open, irq_eval;

  assign off            = acc_addr[OFF_W-1:0];
  assign unused_addr_hi = ^acc_addr[ADDR_W-1:OFF_W];
  assign upd_val        = {eng_upd_src, eng_upd_dst, eng_upd_bytes};

  dcr_decode u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .off       (off),
    .acc_size  (acc_size),
    .wsel      (wsel)
  );

  dcr_ctrl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wsel.ctrl),
    .wval       (acc_wdata[31:0]),
    .eng_done   (eng_done),
    .eng_err    (eng_err),
    .ctrl_q     (ctrl_q),
    .claim_rise (claim_rise),
    .start_now  (start_now),
    .start_q    (eng_start),
    .gate_open  (gate_open),
    .irq_eval   (irq_eval),
    .irq_done_q (irq_done),
    .irq_err_q  (irq_err)
  );

  dcr_desc u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .wsel       (wsel),
    .wdata      (acc_wdata),
    .claim_rise (claim_rise),
    .start_now  (start_now),
    .eng_upd    (eng_upd),
    .upd_val    (upd_val),
    .cfg_q      (cfg_q),
    .xcfg_q     (xcfg_q),
    .next_q     (next_q),
    .exec_q     (exec_q)
  );

  dcr_rdmux u_rd (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .off       (off),
    .acc_size  (acc_size),
    .ctrl_q    (ctrl_q),
    .cfg_q     (cfg_q),
    .xcfg_q    (xcfg_q),
    .next_q    (next_q),
    .exec_q    (exec_q),
    .acc_rdata (acc_rdata)
  );

  assign eng_cfg   = xcfg_q;
  assign eng_bytes = exec_q[IDX_BYTES];
  assign eng_dst   = exec_q[IDX_DST];
  assign eng_src   = exec_q[IDX_SRC];

endmodule

// File: rtl/dcr_chk.sv
module dcr_chk
  import dma_chan_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_ctrl,
  input logic                   exec_hit,
  input logic [31:0]            wval,
  input logic [31:0]            ctrl,
  input logic [31:0]            cfg_q,
  input logic [31:0]            xcfg_q,
  input logic [NDESC-1:0][63:0] next_q,
  input logic [NDESC-1:0][63:0] exec_q,
  input logic                   eng_start,
  input logic [31:0]            eng_cfg,
  input logic [63:0]            eng_bytes,
  input logic [63:0]            eng_dst,
  input logic [63:0]            eng_src,
  input logic                   eng_done,
  input logic                   eng_upd,
  input logic                   irq_done,
  input logic                   irq_err
);

  AST_CLAIM_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && ctrl[B_RUN] && !wval[B_CLAIM]) |=> ctrl[B_CLAIM]); // R4

  AST_UNCLAIMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !ctrl[B_CLAIM]) |=> (!ctrl[B_RUN] && !eng_start)); // R5

  AST_START_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (eng_bytes == $past(next_q[IDX_BYTES]) && eng_dst == $past(next_q[IDX_DST])
                   && eng_src == $past(next_q[IDX_SRC]) && eng_cfg == $past(cfg_q))); // R6

  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !$past(eng_done)) |-> !ctrl[B_DONE]); // R6

  AST_EXEC_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_hit && !eng_upd) |=> ($stable(exec_q) && $stable(xcfg_q))); // R8

  AST_IRQ_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> (ctrl[B_DONE] && ctrl[B_DONE_IE])); // R9

  AST_IRQ_ERR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> (ctrl[B_ERR] && ctrl[B_ERR_IE])); // R9

  AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (!ctrl[B_RUN] && ctrl[B_DONE])); // R10

endmodule

bind dma_chan_regs dcr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_ctrl   (wsel.ctrl),
  .exec_hit  (wsel.exec_hit),
  .wval      (acc_wdata[31:0]),
  .ctrl      (ctrl_q),
  .cfg_q     (cfg_q),
  .xcfg_q    (xcfg_q),
  .next_q    (next_q),
  .exec_q    (exec_q),
  .eng_start (eng_start),
  .eng_cfg   (eng_cfg),
  .eng_bytes (eng_bytes),
  .eng_dst   (eng_dst),
  .eng_src   (eng_src),
  .eng_done  (eng_done),
  .eng_upd   (eng_upd),
  .irq_done  (irq_done),
  .irq_err   (irq_err)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [3:0]  acc_size = '0;
  logic [63:0] acc_wdata = '0, acc_rdata;
  logic        eng_start;
  logic [31:0] eng_cfg;
  logic [63:0] eng_bytes, eng_dst, eng_src;
  logic        eng_done = 1'b0, eng_err = 1'b0, eng_upd = 1'b0;
  logic [63:0] eng_upd_bytes = '0, eng_upd_dst = '0, eng_upd_src = '0;
  logic        irq_done, irq_err;

  always #4 clk = ~clk;

  dma_chan_regs #(.ADDR_W(16)) u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] m_ctrl, m_cfg, m_xcfg;
  logic [63:0] m_next [3];
  logic [63:0] m_exec [3];
  logic        m_irqd, m_irqe, m_start;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] exp_rd(input logic [15:0] addr, input logic [3:0] sz);
    logic [11:0] o;
    int k;
    o = addr[11:0];
    if (sz == 4'd4) begin
      if (o == 12'h000) return {32'h0, m_ctrl};
      if (o == 12'h004) return {32'h0, m_cfg};
      if (o == 12'h104) return {32'h0, m_xcfg};
      if (o >= 12'h008 && o < 12'h020 && o[1:0] == 2'b00) begin
        k = int'((o - 12'h008) >> 3);
        return {32'h0, o[2] ? m_next[k][63:32] : m_next[k][31:0]};
      end
      if (o >= 12'h108 && o < 12'h120 && o[1:0] == 2'b00) begin
        k = int'((o - 12'h108) >> 3);
        return {32'h0, o[2] ? m_exec[k][63:32] : m_exec[k][31:0]};
      end
    end else if (sz == 4'd8 && o[2:0] == 3'b000) begin
      if (o >= 12'h008 && o < 12'h020) return m_next[int'((o - 12'h008) >> 3)];
      if (o >= 12'h108 && o < 12'h120) return m_exec[int'((o - 12'h108) >> 3)];
    end
    return 64'h0;
  endfunction

  task automatic model_ctrl(input logic [31:0] val);
    logic c, r;
    logic [31:0] v;
    v = val;
    c = m_ctrl[0];
    r = m_ctrl[1];
    if (!c && v[0]) begin
      m_cfg = 32'h6600_0000;
      foreach (m_next[i]) m_next[i] = 64'h0;
    end
    if (r && !v[0]) v[0] = 1'b1;
    if (!c || (!r && !v[0])) begin
      v[1] = 1'b0;
      m_ctrl = v;
    end else begin
      if (v[1]) begin
        m_start = 1'b1;
        v[30] = 1'b0;
        v[31] = 1'b0;
        m_xcfg = m_cfg;
        foreach (m_exec[i]) m_exec[i] = m_next[i];
      end
      m_ctrl = v;
      m_irqd = v[30] & v[14];
      m_irqe = v[31] & v[15];
    end
  endtask

  task automatic model_wr(input logic [15:0] addr, input logic [3:0] sz, input logic [63:0] d);
    logic [11:0] o;
    int k;
    o = addr[11:0];
    m_start = 1'b0;
    if (sz == 4'd4) begin
      if (o == 12'h000) model_ctrl(d[31:0]);
      else if (o == 12'h004) m_cfg = d[31:0];
      else if (o >= 12'h008 && o < 12'h020 && o[1:0] == 2'b00) begin
        k = int'((o - 12'h008) >> 3);
        if (o[2]) m_next[k][63:32] = d[31:0];
        else      m_next[k][31:0]  = d[31:0];
      end
    end else if (sz == 4'd8 && o[2:0] == 3'b000 && o >= 12'h008 && o < 12'h020) begin
      m_next[int'((o - 12'h008) >> 3)] = d;
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    model_wr(a, s, d);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [3:0] s, input string req);
    logic [63:0] q;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = s;
    #2 q = acc_rdata;
    acc_valid = 1'b0;
    chk(req, q, exp_rd(a, s));
  endtask

  // call right after bus_wr or eng_pulse
  task automatic state_chk(input string req);
    chk(req, {63'h0, irq_done}, {63'h0, m_irqd});
    chk(req, {63'h0, irq_err},  {63'h0, m_irqe});
    chk(req, {63'h0, eng_start}, {63'h0, m_start});
  endtask

  task automatic eng_pulse(input logic d, input logic e, input logic u,
                           input logic [63:0] b, input logic [63:0] ds, input logic [63:0] sr);
    @(negedge clk);
    eng_done = d; eng_err = e; eng_upd = u;
    eng_upd_bytes = b; eng_upd_dst = ds; eng_upd_src = sr;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0; eng_upd = 1'b0;
    m_start = 1'b0;
    if (u) begin m_exec[0] = b; m_exec[1] = ds; m_exec[2] = sr; end
    if (d) begin m_ctrl[1] = 1'b0; m_ctrl[30] = 1'b1; end
    if (e) m_ctrl[31] = 1'b1;
    if (d || e) begin
      m_irqd = m_ctrl[30] & m_ctrl[14];
      m_irqe = m_ctrl[31] & m_ctrl[15];
    end
  endtask

  function automatic logic [11:0] pick_off(input int n);
    case (n)
      0: return 12'h000;  1: return 12'h004;  2: return 12'h008;  3: return 12'h00C;
      4: return 12'h010;  5: return 12'h014;  6: return 12'h018;  7: return 12'h01C;
      8: return 12'h104;  9: return 12'h108; 10: return 12'h10C; 11: return 12'h110;
      12: return 12'h114; 13: return 12'h118; 14: return 12'h11C; 15: return 12'h020;
      default: return 12'h100;
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = '0; m_cfg = 32'h6600_0000; m_xcfg = '0;
    foreach (m_next[i]) begin m_next[i] = '0; m_exec[i] = '0; end
    m_irqd = 1'b0; m_irqe = 1'b0; m_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    state_chk("R1");
    rd_chk(16'h0000, 4'd4, "R1");
    rd_chk(16'h0004, 4'd4, "R1");
    rd_chk(16'h0018, 4'd8, "R1");
    rd_chk(16'h0108, 4'd8, "R1");

    // R2 offset masking
    bus_wr(16'hA004, 4'd4, 64'h0000_0000_1234_5678);
    rd_chk(16'h5004, 4'd4, "R2");
    rd_chk(16'h0004, 4'd4, "R2");

    // R5 run on an unclaimed channel, status writes there do not raise interrupts
    bus_wr(16'h0000, 4'd4, 64'h2);
    state_chk("R5");
    rd_chk(16'h0000, 4'd4, "R5");
    bus_wr(16'h0000, 4'd4, 64'hC000_C000);
    state_chk("R5");
    rd_chk(16'h0000, 4'd4, "R5");

    // R3 claim rise resets staged registers
    bus_wr(16'h0008, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD);
    bus_wr(16'h0010, 4'd8, 64'h1111_2222_3333_4444);
    bus_wr(16'h0004, 4'd4, 64'h11);
    bus_wr(16'h0000, 4'd4, 64'h1);
    rd_chk(16'h0008, 4'd8, "R3");
    rd_chk(16'h0010, 4'd8, "R3");
    rd_chk(16'h0004, 4'd4, "R3");

    // R9 interrupt re-evaluation on gated writes
    bus_wr(16'h0000, 4'd4, 64'h4000_4001);
    state_chk("R9");
    bus_wr(16'h0000, 4'd4, 64'h8000_8001);
    state_chk("R9");

    // R3 re-claim while claimed keeps staged values
    bus_wr(16'h0008, 4'd8, 64'h0000_0000_0000_0100);
    bus_wr(16'h0000, 4'd4, 64'h1);
    rd_chk(16'h0008, 4'd8, "R3");
    state_chk("R9");

    // R7 whole and half accesses
    bus_wr(16'h0010, 4'd8, 64'h0123_4567_89AB_CDEF);
    bus_wr(16'h0014, 4'd4, 64'hFFFF_FFFF_DEAD_BEEF);
    rd_chk(16'h0010, 4'd8, "R7");
    rd_chk(16'h0010, 4'd4, "R7");
    rd_chk(16'h0014, 4'd4, "R7");
    bus_wr(16'h0018, 4'd4, 64'h0000_0000_5555_AAAA);
    rd_chk(16'h0018, 4'd8, "R7");
    bus_wr(16'h0004, 4'd4, 64'h3300_0004);

    // R6 start
    bus_wr(16'h0000, 4'd4, 64'h3);
    state_chk("R6");
    chk("R6", eng_bytes, m_exec[0]);
    chk("R6", eng_dst, m_exec[1]);
    chk("R6", eng_src, m_exec[2]);
    chk("R6", {32'h0, eng_cfg}, {32'h0, m_xcfg});
    @(negedge clk);
    chk("R6", {63'h0, eng_start}, 64'h0);
    rd_chk(16'h0110, 4'd8, "R6");
    rd_chk(16'h0104, 4'd4, "R6");

    // R4 claim pinned while running
    bus_wr(16'h0000, 4'd4, 64'h0);
    state_chk("R4");
    rd_chk(16'h0000, 4'd4, "R4");

    // R10 engine events
    bus_wr(16'h0000, 4'd4, 64'hC003);
    state_chk("R10");
    eng_pulse(1'b1, 1'b0, 1'b0, '0, '0, '0);
    state_chk("R10");
    rd_chk(16'h0000, 4'd4, "R10");
    eng_pulse(1'b0, 1'b1, 1'b0, '0, '0, '0);
    state_chk("R10");
    rd_chk(16'h0000, 4'd4, "R10");

    // R11 progress updates and start priority
    eng_pulse(1'b0, 1'b0, 1'b1, 64'h77, 64'h8000_0000_0000_1000, 64'h4000_0040);
    rd_chk(16'h0108, 4'd8, "R11");
    rd_chk(16'h0114, 4'd4, "R11");
    rd_chk(16'h0118, 4'd8, "R11");
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 16'h0000; acc_size = 4'd4; acc_wdata = 64'h3;
    eng_upd = 1'b1; eng_upd_bytes = 64'h9999; eng_upd_dst = 64'h9999; eng_upd_src = 64'h9999;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; eng_upd = 1'b0;
    model_wr(16'h0000, 4'd4, 64'h3);
    state_chk("R11");
    rd_chk(16'h0108, 4'd8, "R11");
    rd_chk(16'h0110, 4'd8, "R11");

    // R8 executing registers are read-only
    bus_wr(16'h0108, 4'd8, 64'hDEAD_DEAD_DEAD_DEAD);
    bus_wr(16'h0104, 4'd4, 64'hFFFF_FFFF);
    bus_wr(16'h011C, 4'd4, 64'h1234_5678);
    rd_chk(16'h0108, 4'd8, "R8");
    rd_chk(16'h0104, 4'd4, "R8");
    rd_chk(16'h0118, 4'd8, "R8");

    // R12 undefined offsets and sizes
    rd_chk(16'h0020, 4'd4, "R12");
    rd_chk(16'h0000, 4'd8, "R12");
    rd_chk(16'h0004, 4'd2, "R12");
    rd_chk(16'h000C, 4'd8, "R12");
    bus_wr(16'h0004, 4'd2, 64'hABCD);
    rd_chk(16'h0004, 4'd4, "R12");
    bus_wr(16'h0000, 4'd8, 64'h0);
    state_chk("R12");
    rd_chk(16'h0000, 4'd4, "R12");

    // randomized mix, R7 reads against the model
    for (int it = 0; it < 600; it++) begin
      int r, sz_sel;
      logic [3:0]  sz;
      logic [15:0] a;
      logic [63:0] d;
      r      = int'($urandom % 10);
      sz_sel = int'($urandom % 4);
      sz     = (sz_sel == 2) ? 4'd8 : ((sz_sel == 3) ? 4'd2 : 4'd4);
      a      = {4'($urandom), pick_off(int'($urandom % 17))};
      d      = {$urandom, $urandom};
      if (r < 4) begin
        rd_chk(a, sz, "R7");
      end else if (r < 8) begin
        if (a[11:0] == 12'h000) d[31:0] = d[31:0] & 32'hC000_C003;
        bus_wr(a, sz, d);
        state_chk("R5");
      end else begin
        eng_pulse(1'($urandom), 1'($urandom), 1'($urandom), d, {$urandom, $urandom}, ~d);
        state_chk("R10");
      end
    end

    for (int i = 0; i < 17; i++) rd_chk({4'h0, pick_off(i)}, 4'd4, "R7");
    for (int i = 0; i < 17; i++) rd_chk({4'h0, pick_off(i)}, 4'd8, "R7");

    summary();
    $finish;
  end

endmodule